// File: doc/BRIEF.md
# Transport Packet Sync Locker

This block finds packet boundaries in a transport stream that arrives from a channel decoder. The stream can come as whole bytes or as single bits, and a configuration input selects which. While searching, every received byte is compared with the sync value 0x47. In bit mode the comparison runs at every bit position, so the byte boundary is found without help. After a first hit the block checks the byte that falls one packet length later (188 bytes). It declares lock once enough sync bytes in a row have arrived at that spacing.

Once locked, the block passes every byte through with a valid flag and marks each packet's leading sync byte with a start strobe. It holds lock through short disturbances and drops back to searching only after a programmed number of expected sync positions in a row fail to carry the sync value. Both thresholds can be set at run time. Changing the input mode restarts the search.

Top module: `ts_sync_locker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `locked`, `out_valid` and `pkt_start` are low.
- R2: From searching, `locked` rises after `lock_count` consecutive sync bytes (0x47), each 188 bytes after the previous one. A `lock_count` of 0 acts as 1. The byte that completes lock is the first byte output, one clock after it is accepted.
- R3: While verifying, a byte other than 0x47 at the expected sync position returns the block to searching, and counting starts again from the next sync byte found.
- R4: While locked, `locked` falls after `unlock_count` consecutive expected sync positions miss 0x47 (0 acts as 1). A hit at a sync position clears the miss count, and lock holds across cycles with no input byte.
- R5: `out_valid` is high only while `locked` is high. Each accepted byte appears on `out_data` exactly one clock after it is accepted. Bytes seen while searching or verifying are never output, and neither is the byte whose miss drops lock.
- R6: `pkt_start` is high with `out_valid` only for a 0x47 byte at a packet's sync position. A missed sync position that keeps lock is output with `pkt_start` low.
- R7: When `serial_mode` is 0, one byte is accepted from `par_data` in each cycle with `par_valid` high, and `ser_bit`/`ser_valid` have no effect. When `serial_mode` is 1, `par_data`/`par_valid` have no effect.
- R8: When `serial_mode` is 1, one bit is accepted from `ser_bit` in each cycle with `ser_valid` high, most significant bit first. While searching, the sync value is matched at any bit offset, and later bytes are formed on that alignment.
- R9: A change of `serial_mode` returns the block to searching. `locked` is low in the next cycle, and input presented in the cycle of the change is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 = bit-serial input, 0 = byte-parallel input |
| par_data | input | 8 | Parallel input byte |
| par_valid | input | 1 | Parallel byte present |
| ser_bit | input | 1 | Serial input bit |
| ser_valid | input | 1 | Serial bit present |
| lock_count | input | 4 | Consecutive sync hits needed to lock |
| unlock_count | input | 4 | Consecutive sync misses needed to drop lock |
| locked | output | 1 | Block is aligned to packets |
| out_data | output | 8 | Aligned output byte |
| out_valid | output | 1 | `out_data` holds a byte |
| pkt_start | output | 1 | Output byte is a packet's leading sync byte |

## Verification
The byte that completes lock triggers three things in the same clock: lock entry, the first data output, and the packet-start strobe. The bench provokes this with streams of several packets, under thresholds of 0, 2 and 3 and in both input modes. The scoreboard requires the very first popped item to be that sync byte with its start flag set, and `locked` must read high in that same cycle. Lock loss coincides in a similar way with the suppression of the missing byte. A scoreboard that expects nothing from that packet judges this case.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h47;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    typedef struct packed {
        logic       valid;
        logic       start;
        logic [7:0] data;
    } out_beat_t;

    function automatic logic is_sync(input logic [7:0] b);
        return b == SYNC_BYTE;
    endfunction

endpackage

// File: rtl/ts_byte_assembler.sv
module ts_byte_assembler
    import ts_sync_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       serial_mode,
    input  logic       hunting,
    input  logic [7:0] par_data,
    input  logic       par_valid,
    input  logic       ser_bit,
    input  logic       ser_valid,
    output byte_beat_t beat
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [7:0]       shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       window;

    // MSB first: the newest bit enters at the bottom
    assign window = {shreg[6:0], ser_bit};

    always_comb begin
        if (serial_mode) begin
            beat.valid = ser_valid && !flush && (hunting || bit_cnt == LAST_BIT);
            beat.data  = window;
        end else begin
            beat.valid = par_valid && !flush;
            beat.data  = par_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (serial_mode && ser_valid) begin
            shreg <= window;
            if (hunting && is_sync(window))
                bit_cnt <= '0;
            else
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ts_lock_fsm.sv
module ts_lock_fsm
    import ts_sync_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int THR_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  byte_beat_t       beat,
    input  logic [THR_W-1:0] lock_count,
    input  logic [THR_W-1:0] unlock_count,
    output lock_state_e      state,
    output out_beat_t        emit
);
    localparam int POS_W = $clog2(PKT_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);
    localparam logic [THR_W:0]   ONE      = (THR_W + 1)'(1);

    lock_state_e      nxt;
    logic [POS_W-1:0] pos, pos_n;
    logic [THR_W:0]   good, good_n;
    logic [THR_W:0]   miss, miss_n;
    logic [THR_W:0]   lock_need, unlock_need;
    logic             hit;

    assign lock_need   = (lock_count == '0)   ? ONE : {1'b0, lock_count};
    assign unlock_need = (unlock_count == '0) ? ONE : {1'b0, unlock_count};
    assign hit         = is_sync(beat.data);

    always_comb begin
        nxt    = state;
        pos_n  = pos;
        good_n = good;
        miss_n = miss;
        if (beat.valid) begin
            pos_n = (pos == LAST_POS) ? '0 : pos + 1'b1;
            case (state)
                ST_HUNT: begin
                    if (hit) begin
                        pos_n  = POS_W'(1);
                        good_n = ONE;
                        miss_n = '0;
                        nxt    = (lock_need == ONE) ? ST_LOCKED : ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (pos == '0) begin
                        if (hit) begin
                            good_n = good + 1'b1;
                            if (good + 1'b1 >= lock_need) begin
                                nxt    = ST_LOCKED;
                                miss_n = '0;
                            end
                        end else begin
                            good_n = '0;
                            nxt    = ST_HUNT;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (pos == '0) begin
                        if (hit) begin
                            miss_n = '0;
                        end else if (miss + 1'b1 >= unlock_need) begin
                            miss_n = '0;
                            good_n = '0;
                            nxt    = ST_HUNT;
                        end else begin
                            miss_n = miss + 1'b1;
                        end
                    end
                end
                default: nxt = ST_HUNT;
            endcase
        end
    end

    always_comb begin
        emit.valid = beat.valid && (nxt == ST_LOCKED);
        emit.data  = beat.data;
        emit.start = emit.valid && hit && (state == ST_HUNT || pos == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= ST_HUNT;
            pos   <= '0;
            good  <= '0;
            miss  <= '0;
        end else begin
            state <= nxt;
            pos   <= pos_n;
            good  <= good_n;
            miss  <= miss_n;
        end
    end

    // R2: a direct jump from search to lock needs a threshold of one or zero
    assert_hunt_skip_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_HUNT && state == ST_LOCKED) |-> ($past(lock_count) <= THR_W'(1)));

    // R4: without an input byte or a mode change, lock is held
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED && !flush && !beat.valid) |=> state == ST_LOCKED);

endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage
    import ts_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  out_beat_t  emit,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       pkt_start
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pkt_start <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit.valid;
            pkt_start <= emit.start;
            if (emit.valid)
                out_data <= emit.data;
        end
    end

    // R6: the start strobe accompanies only a valid sync byte
    assert_start_is_sync_R6: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> (out_valid && out_data == SYNC_BYTE));

endmodule

// File: rtl/ts_sync_locker.sv
module ts_sync_locker
    import ts_sync_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int THR_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             serial_mode,
    input  logic [7:0]       par_data,
    input  logic             par_valid,
    input  logic             ser_bit,
    input  logic             ser_valid,
    input  logic [THR_W-1:0] lock_count,
    input  logic [THR_W-1:0] unlock_count,
    output logic             locked,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             pkt_start
);
    logic        mode_q;
    logic        mode_chg;
    byte_beat_t  beat;
    out_beat_t   emit;
    lock_state_e state;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= serial_mode;
        else     mode_q <= serial_mode;
    end

    assign mode_chg = !rst && (serial_mode != mode_q);
    assign locked   = (state == ST_LOCKED);

    ts_byte_assembler #(.BYTE_W(8)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .flush      (mode_chg),
        .serial_mode(serial_mode),
        .hunting    (state == ST_HUNT),
        .par_data   (par_data),
        .par_valid  (par_valid),
        .ser_bit    (ser_bit),
        .ser_valid  (ser_valid),
        .beat       (beat)
    );

    ts_lock_fsm #(.PKT_LEN(PKT_LEN), .THR_W(THR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .flush       (mode_chg),
        .beat        (beat),
        .lock_count  (lock_count),
        .unlock_count(unlock_count),
        .state       (state),
        .emit        (emit)
    );

    ts_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .emit     (emit),
        .out_data (out_data),
        .out_valid(out_valid),
        .pkt_start(pkt_start)
    );

    // R5: no data leaves the block unless it is locked
    assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> locked);

    // R9: a mode change always ends in search
    assert_mode_change_hunts_R9: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !locked);

endmodule

// File: tb/ts_sync_locker_test.sv
module ts_sync_locker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_mode = 1'b0;
    logic [7:0] par_data = 8'h00;
    logic       par_valid = 1'b0;
    logic       ser_bit = 1'b0;
    logic       ser_valid = 1'b0;
    logic [3:0] lock_count = 4'd3;
    logic [3:0] unlock_count = 4'd2;
    logic       locked;
    logic [7:0] out_data;
    logic       out_valid;
    logic       pkt_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [8:0] expq[$];

    always #5 clk = ~clk;

    ts_sync_locker uut (
        .clk(clk), .rst(rst), .serial_mode(serial_mode),
        .par_data(par_data), .par_valid(par_valid),
        .ser_bit(ser_bit), .ser_valid(ser_valid),
        .lock_count(lock_count), .unlock_count(unlock_count),
        .locked(locked), .out_data(out_data),
        .out_valid(out_valid), .pkt_start(pkt_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when the design produces a byte
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected output", {23'd0, pkt_start, out_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    check(out_data == e[7:0], "R5 data", out_data, e[7:0]);
                    check(pkt_start == e[8], "R6 start", pkt_start, e[8]);
                end
            end else if (pkt_start) begin
                check(1'b0, "R6 start without valid", 1, 0);
            end
        end
    end

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            par_valid = 1'b0;
            ser_valid = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input bit exp, input bit st);
        if (serial_mode) begin
            for (int i = 7; i >= 0; i--) begin
                @(negedge clk);
                par_valid = 1'b0;
                ser_bit   = d[i];
                ser_valid = 1'b1;
                if (i == 0 && exp) expq.push_back({st, d});
            end
        end else begin
            @(negedge clk);
            ser_valid = 1'b0;
            par_data  = d;
            par_valid = 1'b1;
            if (exp) expq.push_back({st, d});
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_bit   = b[i];
            ser_valid = 1'b1;
        end
    endtask

    // good: sync byte at the head; exp: whole packet expected at the output
    task automatic send_packet(input bit good, input bit exp, input logic [7:0] seed);
        logic [7:0] head;
        head = good ? 8'h47 : (serial_mode ? 8'h00 : 8'hB8);
        send_byte(head, exp, good);
        for (int k = 1; k < 188; k++) begin
            logic [7:0] d;
            d = serial_mode ? 8'h11 : ((seed + 8'(k)) & 8'h3F);
            send_byte(d, exp, 1'b0);
        end
    endtask

    task automatic drain(input string req);
        quiet(3);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(locked == 1'b0, "R1 locked in reset", locked, 0);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(pkt_start == 1'b0, "R1 pkt_start in reset", pkt_start, 0);
        rst = 1'b0;
        @(negedge clk);
        check(locked == 1'b0, "R1 locked after reset", locked, 0);

        // R2: parallel lock after three spaced sync bytes
        lock_count = 4'd3; unlock_count = 4'd2;
        send_packet(1'b1, 1'b0, 8'd1);
        send_packet(1'b1, 1'b0, 8'd2);
        send_packet(1'b1, 1'b1, 8'd3);
        drain("R2 lock packet outputs");
        check(locked == 1'b1, "R2 locked after threshold", locked, 1);

        // R7: serial lane ignored in parallel mode
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_bit = i[0];
            ser_valid = 1'b1;
        end
        quiet(2);
        check(locked == 1'b1, "R7 serial lane ignored", locked, 1);
        send_packet(1'b1, 1'b1, 8'd4);
        drain("R7 alignment kept");

        // R4/R6: one miss holds lock, hit clears, two misses drop
        send_packet(1'b0, 1'b1, 8'd5);
        drain("R6 missed head output without start");
        check(locked == 1'b1, "R4 lock held after one miss", locked, 1);
        send_packet(1'b1, 1'b1, 8'd6);
        send_packet(1'b0, 1'b1, 8'd7);
        drain("R4 hit clears miss count");
        check(locked == 1'b1, "R4 miss count was cleared", locked, 1);
        send_packet(1'b0, 1'b0, 8'd8);
        drain("R5 nothing after lock loss");
        check(locked == 1'b0, "R4 lock dropped", locked, 0);

        // R3: verify failure restarts the count
        send_packet(1'b1, 1'b0, 8'd9);
        send_packet(1'b1, 1'b0, 8'd10);
        send_packet(1'b0, 1'b0, 8'd11);
        send_packet(1'b1, 1'b0, 8'd12);
        send_packet(1'b1, 1'b0, 8'd13);
        quiet(2);
        check(locked == 1'b0, "R3 count restarted", locked, 0);
        send_packet(1'b1, 1'b1, 8'd14);
        drain("R3 lock after restart");
        check(locked == 1'b1, "R3 locked after restart", locked, 1);

        // R9: mode change drops lock
        @(negedge clk);
        serial_mode = 1'b1;
        @(negedge clk);
        check(locked == 1'b0, "R9 lock dropped on mode change", locked, 0);

        // R7: parallel lane ignored in serial mode
        lock_count = 4'd1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            par_data = 8'h47;
            par_valid = 1'b1;
        end
        quiet(2);
        check(locked == 1'b0, "R7 parallel lane ignored", locked, 0);

        // R8: serial lock at an arbitrary bit offset
        lock_count = 4'd2; unlock_count = 4'd1;
        send_bits(8'b0000_0101, 3);
        send_packet(1'b1, 1'b0, 8'd0);
        send_packet(1'b1, 1'b1, 8'd0);
        drain("R8 serial lock packet");
        check(locked == 1'b1, "R8 serial locked", locked, 1);
        send_packet(1'b0, 1'b0, 8'd0);
        drain("R4 serial single miss drops");
        check(locked == 1'b0, "R4 serial unlock threshold one", locked, 0);

        // R2: threshold zero acts as one
        lock_count = 4'd0;
        send_packet(1'b1, 1'b1, 8'd0);
        drain("R2 zero threshold lock");
        check(locked == 1'b1, "R2 zero threshold locked", locked, 1);

        // R9: back to parallel, input in the change cycle discarded
        @(negedge clk);
        serial_mode = 1'b0;
        par_data = 8'h47;
        par_valid = 1'b1;
        ser_valid = 1'b0;
        quiet(1);
        check(locked == 1'b0, "R9 change-cycle input discarded", locked, 0);
        send_packet(1'b1, 1'b1, 8'd20);
        drain("R9 relock after mode change");
        check(locked == 1'b1, "R9 locked again", locked, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule